// File: doc/BRIEF.md
# Page Fill, Copy and Arithmetic Engine

This engine sits next to a memory controller and carries out whole-page operations without the processor moving data word by word. One command names an operation, a page-aligned destination page and up to two page-aligned source pages, plus a fill constant. The engine then walks the page one memory word at a time on a simple synchronous memory port. For each word it reads the source operands it needs and writes the result to the destination.

Before it modifies any cache line of the destination page, the engine raises a line-invalidate request and waits for the acknowledge, so no cached copy of the old data survives. It also reports each DRAM row it opens on the memory port. Commands are taken through a ready/valid pair. A one-cycle done pulse closes every command, and a command with a misaligned operand is refused with an error pulse.

Top module: `pme_page_engine`

## Requirements
- R1: `cmd_ready` is high exactly while the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. From the next cycle `busy` is high and `cmd_ready` is low until the command ends, and a command offered meanwhile is neither taken nor carried out.
- R2: Operation code 0 (fill) writes `cmd_fill` to every word of the destination page exactly once and reads no memory.
- R3: Operation code 1 (copy) writes word k of source page B to word k of the destination page, for every word of the page.
- R4: Operation code 2 (add) writes B[k] + C[k], computed independently in each LANE_W-bit lane (lane 0 in the low bits), with wraparound modulo 2^LANE_W and no carry between lanes.
- R5: Operation code 3 (subtract) writes B[k] - C[k] per LANE_W-bit lane, with wraparound and no borrow between lanes.
- R6: For every LINE_BYTES cache line of the destination page, `inv_req` is raised with the line-aligned byte address on `inv_addr`. It holds with a stable address until `inv_ack`, and the handshake completes before the first write into that line. Each command raises exactly one handshake per line.
- R7: `done` is high for exactly one cycle, the cycle after the last write of the page. In the following cycle `busy` is low and `cmd_ready` is high.
- R8: A command whose destination, or any source that its operation uses, has a nonzero offset within a PAGE_BYTES page is refused. `done` and `err` pulse together for one cycle in the cycle after acceptance, with no memory access and no invalidate. Sources the operation does not use are not checked.
- R9: `mem_act` pulses on an access whose operand (destination, source B or source C) falls in a different ROW_BYTES row than that operand's previous access in the same command, or on that operand's first access. A page operand never needs more than two openings.
- R10: Memory reads return data in the cycle after `mem_req` with `mem_we` low. Writes target only the destination page, and reads target only the sources the operation uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 0 fill, 1 copy, 2 add, 3 subtract |
| cmd_dst | input | ADDR_W | Destination page byte address |
| cmd_srcb | input | ADDR_W | Source page B byte address |
| cmd_srcc | input | ADDR_W | Source page C byte address |
| cmd_fill | input | DATA_W | Fill constant |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Command refused (with done) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after a read |
| mem_act | output | 1 | Access opens a DRAM row for its operand |
| inv_req | output | 1 | Cache line invalidate request |
| inv_addr | output | ADDR_W | Line-aligned byte address to invalidate |
| inv_ack | input | 1 | Invalidate acknowledge |

## Verification
The bench builds the engine with 12-bit addresses, 256-byte pages, 64-byte lines, 128-byte rows and 32-bit lanes inside a 64-bit word. Each page is then 32 beats, four lines and exactly two rows, so whole commands finish in about a hundred cycles and every line and row boundary is crossed many times per run. The narrow lanes put two lanes in each word, so a carry or borrow leaking from lane 0 into lane 1 shows up in the compared data.

// File: rtl/pme_pkg.sv
package pme_pkg;

  typedef enum logic [1:0] {
    OP_FILL = 2'd0,
    OP_COPY = 2'd1,
    OP_ADD  = 2'd2,
    OP_SUB  = 2'd3
  } pme_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INV,
    ST_RDB,
    ST_CAPB,
    ST_CAPC,
    ST_WR,
    ST_FIN,
    ST_REJ
  } pme_state_e;

  localparam int unsigned OPD_DST  = 0;
  localparam int unsigned OPD_SRCB = 1;
  localparam int unsigned OPD_SRCC = 2;
  localparam int unsigned OPD_NUM  = 3;

endpackage

// File: rtl/pme_row_tracker.sv
module pme_row_tracker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ROW_LG = 11,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              touch,
  input  logic [ADDR_W-1:0] addr,
  output logic              act,
  output logic [CNT_W-1:0]  opens
);

  localparam int unsigned RW = ADDR_W - ROW_LG;

  logic [RW-1:0]    row_q, row_d;
  logic             vld_q, vld_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RW-1:0]    row_now;

  assign row_now = addr[ADDR_W-1:ROW_LG];
  assign act     = touch && (!vld_q || (row_now != row_q));
  assign opens   = cnt_q;

  always_comb begin
    row_d = row_q;
    vld_d = vld_q;
    cnt_d = cnt_q;
    if (clear) begin
      vld_d = 1'b0;
      cnt_d = '0;
    end else if (act) begin
      vld_d = 1'b1;
      row_d = row_now;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      row_q <= row_d;
      vld_q <= vld_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pme_lane_alu.sv
module pme_lane_alu
  import pme_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 64
) (
  input  pme_op_e           op,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] opc,
  input  logic [DATA_W-1:0] fill,
  output logic [DATA_W-1:0] res
);

  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] dif_w;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign sum_w[l*LANE_W +: LANE_W] = opb[l*LANE_W +: LANE_W] + opc[l*LANE_W +: LANE_W];
    assign dif_w[l*LANE_W +: LANE_W] = opb[l*LANE_W +: LANE_W] - opc[l*LANE_W +: LANE_W];
  end

  always_comb begin
    unique case (op)
      OP_FILL: res = fill;
      OP_COPY: res = opb;
      OP_ADD:  res = sum_w;
      default: res = dif_w;
    endcase
  end

endmodule

// File: rtl/pme_page_engine.sv
module pme_page_engine
  import pme_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LANE_W     = 64,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned ROW_BYTES  = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_dst,
  input  logic [ADDR_W-1:0] cmd_srcb,
  input  logic [ADDR_W-1:0] cmd_srcc,
  input  logic [DATA_W-1:0] cmd_fill,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_act,
  output logic              inv_req,
  output logic [ADDR_W-1:0] inv_addr,
  input  logic              inv_ack
);

  localparam int unsigned WORD_BYTES = DATA_W / 8;
  localparam int unsigned WORD_LG    = $clog2(WORD_BYTES);
  localparam int unsigned PAGE_LG    = $clog2(PAGE_BYTES);
  localparam int unsigned LINE_LG    = $clog2(LINE_BYTES);
  localparam int unsigned ROW_LG     = $clog2(ROW_BYTES);
  localparam int unsigned BEATS      = PAGE_BYTES / WORD_BYTES;
  localparam int unsigned BEAT_W     = $clog2(BEATS);
  localparam int unsigned LBEAT_LG   = LINE_LG - WORD_LG;
  localparam int unsigned PG_W       = ADDR_W - PAGE_LG;
  localparam int unsigned CNT_W      = 4;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
  localparam logic [BEAT_W-1:0] LINE_MSK  = BEAT_W'((1 << LBEAT_LG) - 1);

  // reset: asserted at once, released through two flops
  logic rst_s1_q, rst_sn_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_sn_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_sn_q <= rst_s1_q;
    end
  end

  pme_state_e        state_q, state_d;
  pme_op_e           op_q;
  logic [PG_W-1:0]   dpg_q, bpg_q, cpg_q;
  logic [DATA_W-1:0] fill_q, b_q, c_q;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BEAT_W-1:0] beat_nx;

  logic accept, misalign, arith, uses_b, ld_b, ld_c;
  pme_op_e    op_in;
  pme_state_e first_st;

  assign op_in    = pme_op_e'(cmd_op);
  assign accept   = cmd_valid && (state_q == ST_IDLE);
  assign uses_b   = (op_in != OP_FILL);
  assign misalign = (|cmd_dst[PAGE_LG-1:0])
                 || (uses_b && (|cmd_srcb[PAGE_LG-1:0]))
                 || (op_in[1] && (|cmd_srcc[PAGE_LG-1:0]));
  assign arith    = op_q[1];
  assign first_st = (op_q == OP_FILL) ? ST_WR : ST_RDB;
  assign beat_nx  = beat_q + 1'b1;
  assign ld_b     = (state_q == ST_CAPB);
  assign ld_c     = (state_q == ST_CAPC);

  // next state
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = misalign ? ST_REJ : ST_INV;
        beat_d  = '0;
      end
      ST_INV:  if (inv_ack) state_d = first_st;
      ST_RDB:  state_d = ST_CAPB;
      ST_CAPB: state_d = arith ? ST_CAPC : ST_WR;
      ST_CAPC: state_d = ST_WR;
      ST_WR: begin
        if (beat_q == LAST_BEAT) begin
          state_d = ST_FIN;
        end else begin
          beat_d  = beat_nx;
          state_d = ((beat_nx & LINE_MSK) == '0) ? ST_INV : first_st;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn_q) begin
    if (!rst_sn_q) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      op_q    <= OP_FILL;
      dpg_q   <= '0;
      bpg_q   <= '0;
      cpg_q   <= '0;
      fill_q  <= '0;
      b_q     <= '0;
      c_q     <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      if (accept) begin
        op_q   <= op_in;
        dpg_q  <= cmd_dst[ADDR_W-1:PAGE_LG];
        bpg_q  <= cmd_srcb[ADDR_W-1:PAGE_LG];
        cpg_q  <= cmd_srcc[ADDR_W-1:PAGE_LG];
        fill_q <= cmd_fill;
      end
      if (ld_b) b_q <= mem_rdata;
      if (ld_c) c_q <= mem_rdata;
    end
  end

  // memory port
  logic [ADDR_W-1:0] dst_addr, b_addr, c_addr;
  logic rd_b, rd_c, wr_d;

  assign dst_addr = {dpg_q, beat_q, {WORD_LG{1'b0}}};
  assign b_addr   = {bpg_q, beat_q, {WORD_LG{1'b0}}};
  assign c_addr   = {cpg_q, beat_q, {WORD_LG{1'b0}}};
  assign rd_b     = (state_q == ST_RDB);
  assign rd_c     = (state_q == ST_CAPB) && arith;
  assign wr_d     = (state_q == ST_WR);

  assign mem_req  = rd_b || rd_c || wr_d;
  assign mem_we   = wr_d;
  assign mem_addr = rd_b ? b_addr : (rd_c ? c_addr : dst_addr);

  pme_lane_alu #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) i_alu (
    .op   (op_q),
    .opb  (b_q),
    .opc  (c_q),
    .fill (fill_q),
    .res  (mem_wdata)
  );

  // row openings, one tracker per operand
  logic [OPD_NUM-1:0]            touch_v, act_v;
  logic [OPD_NUM-1:0][ADDR_W-1:0] addr_v;
  logic [OPD_NUM-1:0][CNT_W-1:0]  row_opens;

  assign touch_v[OPD_DST]  = wr_d;
  assign touch_v[OPD_SRCB] = rd_b;
  assign touch_v[OPD_SRCC] = rd_c;
  assign addr_v[OPD_DST]   = dst_addr;
  assign addr_v[OPD_SRCB]  = b_addr;
  assign addr_v[OPD_SRCC]  = c_addr;

  for (genvar g = 0; g < OPD_NUM; g++) begin : g_row
    pme_row_tracker #(
      .ADDR_W (ADDR_W),
      .ROW_LG (ROW_LG),
      .CNT_W  (CNT_W)
    ) i_trk (
      .clk   (clk),
      .rst_n (rst_sn_q),
      .clear (accept),
      .touch (touch_v[g]),
      .addr  (addr_v[g]),
      .act   (act_v[g]),
      .opens (row_opens[g])
    );
  end

  assign mem_act = |act_v;

  // invalidate and handshake outputs
  assign inv_req   = (state_q == ST_INV);
  assign inv_addr  = {dpg_q, beat_q[BEAT_W-1:LBEAT_LG], {LINE_LG{1'b0}}};
  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN) || (state_q == ST_REJ);
  assign err       = (state_q == ST_REJ);

endmodule

// File: rtl/pme_page_engine_chk.sv
module pme_page_engine_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LINE_BYTES = 128
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic                   busy,
  input logic                   done,
  input logic                   err,
  input logic                   mem_req,
  input logic                   mem_we,
  input logic [ADDR_W-1:0]      mem_addr,
  input logic                   inv_req,
  input logic                   inv_ack,
  input logic [ADDR_W-1:0]      inv_addr,
  input logic [2:0][3:0]        row_opens
);

  localparam int unsigned LINE_LG = $clog2(LINE_BYTES);
  localparam int unsigned WORD_LG = $clog2(DATA_W / 8);

  logic inv_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_seen_q <= 1'b0;
    end else if (inv_req && inv_ack) begin
      inv_seen_q <= 1'b1;
    end else if (mem_req && mem_we && (&mem_addr[LINE_LG-1:WORD_LG])) begin
      inv_seen_q <= 1'b0;
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy && !cmd_ready);
  p_access_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy && !done);
  p_inv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && !inv_ack |=> inv_req && $stable(inv_addr));
  p_inv_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> (inv_addr[LINE_LG-1:0] == '0));
  p_write_after_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> inv_seen_q);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !mem_req && !inv_req);
  p_err_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(cmd_ready));
  p_rows_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    row_opens[0] <= 4'd2);
  p_rows_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    row_opens[1] <= 4'd2);
  p_rows_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    row_opens[2] <= 4'd2);

endmodule

bind pme_page_engine pme_page_engine_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LINE_BYTES (LINE_BYTES)
) i_pme_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .inv_req   (inv_req),
  .inv_ack   (inv_ack),
  .inv_addr  (inv_addr),
  .row_opens (row_opens)
);

// File: tb/test_pme_page_engine.sv
`timescale 1ns/1ps
module test_pme_page_engine;

  localparam int AW = 12;
  localparam int DW = 64;
  localparam int LW = 32;
  localparam int PB = 256;
  localparam int LB = 64;
  localparam int RB = 128;
  localparam int WPP = PB / 8;   // 32 words per page
  localparam int LPP = PB / LB;  // 4 lines per page
  localparam int NW  = (1 << AW) / 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready, busy, done, err;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_dst, cmd_srcb, cmd_srcc;
  logic [DW-1:0] cmd_fill;
  logic mem_req, mem_we, mem_act, inv_req, inv_ack;
  logic [AW-1:0] mem_addr, inv_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  pme_page_engine #(
    .ADDR_W(AW), .DATA_W(DW), .LANE_W(LW),
    .PAGE_BYTES(PB), .LINE_BYTES(LB), .ROW_BYTES(RB)
  ) i_pme_page_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_srcb(cmd_srcb), .cmd_srcc(cmd_srcc),
    .cmd_fill(cmd_fill), .busy(busy), .done(done), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_act(mem_act),
    .inv_req(inv_req), .inv_addr(inv_addr), .inv_ack(inv_ack)
  );

  // memory and invalidate responder with activity counters
  logic [DW-1:0] mem [NW];
  int wr_cnt = 0, rd_cnt = 0, act_cnt = 0, inv_cnt = 0, bad_wr = 0, bad_rd = 0, no_inv = 0;
  int cmd_no = 0;
  int inv_stamp [LPP];
  int dpg_cur = 0, bpg_cur = 0, cpg_cur = 0, nsrc_cur = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      inv_ack <= inv_req && !inv_ack;
      if (inv_req && inv_ack) begin
        inv_cnt <= inv_cnt + 1;
        inv_stamp[inv_addr[7:6]] <= cmd_no;
      end
      if (mem_act) act_cnt <= act_cnt + 1;
      if (mem_req && mem_we) begin
        mem[mem_addr[AW-1:3]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        if (int'(mem_addr[AW-1:8]) != dpg_cur) bad_wr <= bad_wr + 1;
        if (inv_stamp[mem_addr[7:6]] != cmd_no) no_inv <= no_inv + 1;
      end
      if (mem_req && !mem_we) begin
        mem_rdata <= mem[mem_addr[AW-1:3]];
        rd_cnt <= rd_cnt + 1;
        if (!((nsrc_cur >= 1 && int'(mem_addr[AW-1:8]) == bpg_cur) ||
              (nsrc_cur == 2 && int'(mem_addr[AW-1:8]) == cpg_cur)))
          bad_rd <= bad_rd + 1;
      end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] b,
                                        input logic [63:0] c, input logic [63:0] f);
    logic [63:0] r;
    for (int l = 0; l < DW / LW; l++) begin
      case (op)
        2'd0: r[l*LW +: LW] = f[l*LW +: LW];
        2'd1: r[l*LW +: LW] = b[l*LW +: LW];
        2'd2: r[l*LW +: LW] = b[l*LW +: LW] + c[l*LW +: LW];
        default: r[l*LW +: LW] = b[l*LW +: LW] - c[l*LW +: LW];
      endcase
    end
    return r;
  endfunction

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  dpg;
    logic [3:0]  bpg;
    logic [3:0]  cpg;
    logic [63:0] val;
    logic        poke;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd1, 4'd9,  4'd9,  64'hA5A5_0F0F_1234_5678, 1'b0},  // fill, unused sources
    '{2'd1, 4'd2, 4'd3,  4'd9,  64'h0,                   1'b1},  // copy, second command offered while busy
    '{2'd2, 4'd4, 4'd5,  4'd6,  64'h0,                   1'b0},  // add
    '{2'd3, 4'd7, 4'd5,  4'd6,  64'h0,                   1'b0},  // subtract
    '{2'd2, 4'd5, 4'd5,  4'd8,  64'h0,                   1'b0},  // add in place
    '{2'd3, 4'd10, 4'd8, 4'd8,  64'h0,                   1'b0},  // b - b = 0
    '{2'd0, 4'd11, 4'd0, 4'd0,  64'h0,                   1'b0},  // fill zero
    '{2'd3, 4'd12, 4'd13, 4'd14, 64'h0,                  1'b0}   // subtract across lane borrow
  };

  task automatic run_cmd(input logic [1:0] op, input int dpg, input int bpg, input int cpg,
                         input logic [63:0] val, input bit poke,
                         input int doff, input int boff, input int coff);
    logic [63:0] expv [WPP];
    logic [63:0] guard [WPP];
    int w0, r0, a0, i0, bw0, br0, ni0, nsrc, mism, first_bad, wait_n;
    bit rej;
    logic [63:0] first_act, first_exp;
    nsrc = (op == 2'd0) ? 0 : ((op == 2'd1) ? 1 : 2);
    rej  = (doff != 0) || (nsrc >= 1 && boff != 0) || (nsrc == 2 && coff != 0);
    for (int k = 0; k < WPP; k++) begin
      expv[k]  = model(op, mem[bpg*WPP + k], mem[cpg*WPP + k], val);
      guard[k] = mem[15*WPP + k];
      if (rej) expv[k] = mem[dpg*WPP + k];
    end
    @(negedge clk);
    cmd_no++;
    dpg_cur = dpg; bpg_cur = bpg; cpg_cur = cpg; nsrc_cur = nsrc;
    w0 = wr_cnt; r0 = rd_cnt; a0 = act_cnt; i0 = inv_cnt;
    bw0 = bad_wr; br0 = bad_rd; ni0 = no_inv;
    cmd_op = op; cmd_fill = val;
    cmd_dst  = AW'(dpg * PB + doff);
    cmd_srcb = AW'(bpg * PB + boff);
    cmd_srcc = AW'(cpg * PB + coff);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy && !cmd_ready, "R1 busy after accept", {busy, cmd_ready}, 2'b10);
    if (poke) begin
      for (int p = 0; p < 10; p++) begin
        cmd_op = 2'd0; cmd_dst = AW'(15 * PB); cmd_fill = 64'hDEAD; cmd_valid = 1'b1;
        @(negedge clk);
        check(!cmd_ready, "R1 ready low while busy", cmd_ready, 0);
      end
      cmd_valid = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    check(done, "R7 done reached", done, 1);
    if (rej) begin
      check(err && wait_n == 0, "R8 err with done in cycle after accept", {err, 8'(wait_n)}, 9'h100);
    end else begin
      check(!err, "R8 no err on aligned command", err, 0);
    end
    @(negedge clk);
    check(!done && !busy && cmd_ready, "R7 done one cycle then idle", {done, busy, cmd_ready}, 3'b001);
    repeat (4) @(negedge clk);
    mism = 0; first_bad = -1; first_act = '0; first_exp = '0;
    for (int k = 0; k < WPP; k++) begin
      if (mem[dpg*WPP + k] !== expv[k]) begin
        if (first_bad < 0) begin
          first_bad = k; first_act = mem[dpg*WPP + k]; first_exp = expv[k];
        end
        mism++;
      end
    end
    case (op)
      2'd0: check(mism == 0, "R2 fill data", first_act, first_exp);
      2'd1: check(mism == 0, "R3 copy data", first_act, first_exp);
      2'd2: check(mism == 0, "R4 add data", first_act, first_exp);
      default: check(mism == 0, "R5 subtract data", first_act, first_exp);
    endcase
    if (poke) begin
      mism = 0;
      for (int k = 0; k < WPP; k++) if (mem[15*WPP + k] !== guard[k]) mism++;
      check(mism == 0, "R1 command offered while busy not performed", mism, 0);
    end
    if (rej) begin
      check(wr_cnt == w0 && rd_cnt == r0 && inv_cnt == i0, "R8 no access on refusal",
            (wr_cnt - w0) + (rd_cnt - r0) + (inv_cnt - i0), 0);
    end else begin
      check(wr_cnt - w0 == WPP, "R2 one write per word", wr_cnt - w0, WPP);
      check(rd_cnt - r0 == nsrc * WPP, "R10 read count", rd_cnt - r0, nsrc * WPP);
      check(bad_wr == bw0 && bad_rd == br0, "R10 accesses stay on operand pages",
            (bad_wr - bw0) + (bad_rd - br0), 0);
      check(inv_cnt - i0 == LPP, "R6 one invalidate per line", inv_cnt - i0, LPP);
      check(no_inv == ni0, "R6 invalidate before write", no_inv - ni0, 0);
      check(act_cnt - a0 == 2 * (nsrc + 1), "R9 row openings", act_cnt - a0, 2 * (nsrc + 1));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    for (int k = 0; k < 32; k++) inv_stamp[k % LPP] = 0;
    for (int i = 0; i < NW; i++)
      mem[i] <= (64'(i) * 64'h9E37_79B9_7F4A_7C15) ^ {32'h0, 32'hFFFF_FFF0};
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_dst = '0; cmd_srcb = '0;
    cmd_srcc = '0; cmd_fill = '0;
    repeat (3) @(negedge clk);
    check(cmd_ready && !busy && !done && !err && !mem_req && !inv_req && !mem_act,
          "R1 reset state", {cmd_ready, busy, done, err, mem_req, inv_req, mem_act}, 7'b1000000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_ready && !busy, "R1 idle after reset", {cmd_ready, busy}, 2'b10);
    // page 13 word lanes: low lane small, page 14 low lane large -> borrow stays in lane 0
    for (int k = 0; k < WPP; k++) begin
      mem[13*WPP + k] <= {32'h0000_0005, 32'h0000_0001};
      mem[14*WPP + k] <= {32'h0000_0001, 32'hFFFF_FFFF};
    end
    @(negedge clk);
    for (int v = 0; v < NV; v++)
      run_cmd(VECS[v].op, int'(VECS[v].dpg), int'(VECS[v].bpg), int'(VECS[v].cpg),
              VECS[v].val, VECS[v].poke, 0, 0, 0);
    // lane wrap in add: low lane all ones plus one wraps to zero without touching high lane
    for (int k = 0; k < WPP; k++) begin
      mem[13*WPP + k] <= {32'h0000_0007, 32'hFFFF_FFFF};
      mem[14*WPP + k] <= {32'h0000_0000, 32'h0000_0001};
    end
    @(negedge clk);
    run_cmd(2'd2, 12, 13, 14, 0, 0, 0, 0, 0);
    check(mem[12*WPP] == {32'h0000_0007, 32'h0000_0000}, "R4 lane wrap without carry",
          mem[12*WPP], {32'h0000_0007, 32'h0000_0000});
    // refusals: misaligned destination, source B on copy, source C on subtract
    run_cmd(2'd0, 3, 0, 0, 64'h1, 0, 8, 0, 0);
    run_cmd(2'd1, 4, 2, 0, 64'h0, 0, 0, 16, 0);
    run_cmd(2'd3, 6, 2, 3, 64'h0, 0, 0, 0, 128);
    // fill ignores a misaligned source it does not use
    run_cmd(2'd0, 9, 0, 0, 64'h5555, 0, 0, 24, 40);
    summary();
  end

endmodule